// File: doc/BRIEF.md
# SPI Chip-Select Delay Timer

This block measures out the two programmable waits that an SPI master inserts around a transfer. The first is the lead wait, from chip-select assertion to the first serial clock edge. The second is the trail wait, the idle gap after a transfer before chip-select may be asserted again. The master's sequencer pulses `start_i` and sets `sel_i` to choose which wait to run. The timer then counts system clock cycles and answers with a single-cycle `done_o` pulse when the wait has elapsed.

Each wait has its own pair of encoded fields. One is a 2-bit prescaler code that selects an odd factor. The other is a 4-bit scaler code that selects a power of two. The wait length is the product of the two factors, in system clock cycles. It is built as two cascaded counters. The prescaler stage emits a tick every P cycles, and the scaler stage finishes after S ticks. The block only sequences time. Shifting, buffering and register access belong to the surrounding master.

Top module: `spi_cs_delay_timer`

## Requirements
- R1: A prescaler code c (2 bits) selects the factor P = 2c+1: code 0 gives 1, code 1 gives 3, code 2 gives 5, code 3 gives 7.
- R2: A scaler code n (4 bits, 0 to 15) selects the factor S = 2^(n+1), so the range is 2 to 65536.
- R3: A start is accepted when `start_i` is high at a rising clock edge while the timer is idle. `done_o` then rises after exactly P*S further rising edges, counting from the accepting edge.
- R4: `sel_i` = 0 at acceptance runs the lead wait, using `lead_pre_i`/`lead_scl_i`. `sel_i` = 1 runs the trail wait, using `trail_pre_i`/`trail_scl_i`.
- R5: `done_o` is high for exactly one clock cycle per accepted start, and is low at all other times.
- R6: A start pulse while the timer is busy is ignored. It neither shortens nor extends the running wait, and it does not cause a later extra `done_o`.
- R7: The select and field inputs are captured at acceptance. Changing them during a running wait has no effect on its length.
- R8: The counters cover the longest wait, 7*65536 = 458752 cycles, without overflow. The scaler count never exceeds S-1 and the prescaler count never exceeds P-1.
- R9: Asserting `rst_n` low returns the timer to idle with both counters cleared, cancels any running wait, and produces no `done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start request, accepted only while idle |
| sel_i | input | 1 | Wait select: 0 lead, 1 trail |
| lead_pre_i | input | 2 | Lead wait prescaler code |
| lead_scl_i | input | 4 | Lead wait scaler code |
| trail_pre_i | input | 2 | Trail wait prescaler code |
| trail_scl_i | input | 4 | Trail wait scaler code |
| done_o | output | 1 | One-cycle pulse when the selected wait has elapsed |

## Verification
The bench measures the edge count from acceptance to `done_o` for every prescaler code, for random scaler codes, and for the largest scaler with P=1. A design with an off-by-one in either stage would show up as a latency of P*S±1 or P*(S±1). A design that decodes the scaler as 2^n would show a halved latency. The bench also issues a second start mid-wait and rewrites the fields mid-wait. A design that restarts, re-reads live inputs or queues the request would produce a wrong latency or a stray second pulse. A reset in the middle of a wait must suppress the pending pulse, and a design that only holds its state during reset would let it through later.

// File: rtl/spi_cs_dly_pkg.sv
package spi_cs_dly_pkg;
  // Field widths of the encoded wait settings
  localparam int unsigned PRE_W  = 2;
  localparam int unsigned SCL_W  = 4;
  // Prescaler factor 2c+1 needs one extra bit
  localparam int unsigned PLEN_W = PRE_W + 1;
  // Largest scaler is 2^(2^SCL_W); its terminal value S-1 needs 2^SCL_W bits,
  // one spare bit keeps the decode arithmetic free of wrap
  localparam int unsigned SCNT_W = (1 << SCL_W) + 1;

  typedef enum logic {
    DLY_LEAD  = 1'b0,
    DLY_TRAIL = 1'b1
  } dly_sel_e;

  typedef struct packed {
    logic [PLEN_W-1:0] pre_len;
    logic [SCNT_W-1:0] scl_last;
  } dly_cfg_t;
endpackage

// File: rtl/cs_dly_field_mux.sv
module cs_dly_field_mux
  import spi_cs_dly_pkg::*;
(
  input  logic             sel_i,
  input  logic [PRE_W-1:0] lead_pre_i,
  input  logic [SCL_W-1:0] lead_scl_i,
  input  logic [PRE_W-1:0] trail_pre_i,
  input  logic [SCL_W-1:0] trail_scl_i,
  output dly_cfg_t         cfg_o
);
  localparam int unsigned SH_W = SCL_W + 1;

  logic [PRE_W-1:0] pre_code;
  logic [SCL_W-1:0] scl_code;
  logic [SH_W-1:0]  shamt;

  always_comb begin
    if (dly_sel_e'(sel_i) == DLY_TRAIL) begin
      pre_code = trail_pre_i;
      scl_code = trail_scl_i;
    end else begin
      pre_code = lead_pre_i;
      scl_code = lead_scl_i;
    end
  end

  // R1: odd factor 2c+1; R2: terminal count 2^(n+1)-1
  always_comb begin
    shamt          = {1'b0, scl_code} + SH_W'(1);
    cfg_o.pre_len  = {pre_code, 1'b1};
    cfg_o.scl_last = (SCNT_W'(1) << shamt) - SCNT_W'(1);
  end
endmodule

// File: rtl/cs_dly_prescale.sv
module cs_dly_prescale
  import spi_cs_dly_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              run_i,
  input  logic [PLEN_W-1:0] pre_len_i,
  output logic              tick_o
);
  logic [PLEN_W-1:0] pcnt_q, pcnt_d;
  logic              pcnt_en;

  assign tick_o  = run_i && (pcnt_q == pre_len_i - PLEN_W'(1));
  assign pcnt_en = clr_i || run_i;

  always_comb begin
    pcnt_d = pcnt_q;
    if (clr_i)       pcnt_d = '0;
    else if (tick_o) pcnt_d = '0;
    else if (run_i)  pcnt_d = pcnt_q + PLEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (pcnt_en) pcnt_q <= pcnt_d;
  end

  // R8: prescaler count stays below its factor while running
  a_r8_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (pcnt_q < pre_len_i));
endmodule

// File: rtl/cs_dly_scaler.sv
module cs_dly_scaler
  import spi_cs_dly_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              run_i,
  input  logic              adv_i,
  input  logic [SCNT_W-1:0] scl_last_i,
  output logic              wrap_o
);
  logic [SCNT_W-1:0] scnt_q, scnt_d;
  logic              scnt_en;

  assign wrap_o  = adv_i && (scnt_q == scl_last_i);
  assign scnt_en = clr_i || adv_i;

  always_comb begin
    scnt_d = scnt_q;
    if (clr_i)       scnt_d = '0;
    else if (wrap_o) scnt_d = '0;
    else if (adv_i)  scnt_d = scnt_q + SCNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       scnt_q <= '0;
    else if (scnt_en) scnt_d_guard: scnt_q <= scnt_d;
  end

  // R8: scaler count never passes its terminal value
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (scnt_q <= scl_last_i));
  // R8: scaler advances only on prescaler ticks
  a_r8_adv_only_run: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |-> run_i);
endmodule

// File: rtl/spi_cs_delay_timer.sv
module spi_cs_delay_timer
  import spi_cs_dly_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             sel_i,
  input  logic [PRE_W-1:0] lead_pre_i,
  input  logic [SCL_W-1:0] lead_scl_i,
  input  logic [PRE_W-1:0] trail_pre_i,
  input  logic [SCL_W-1:0] trail_scl_i,
  output logic             done_o
);
  dly_cfg_t cfg_live;
  dly_cfg_t cfg_q, cfg_d;
  logic     busy_q, busy_d;
  logic     done_q, done_d;
  logic     accept;
  logic     tick;
  logic     wrap;

  cs_dly_field_mux u_mux (
    .sel_i       (sel_i),
    .lead_pre_i  (lead_pre_i),
    .lead_scl_i  (lead_scl_i),
    .trail_pre_i (trail_pre_i),
    .trail_scl_i (trail_scl_i),
    .cfg_o       (cfg_live)
  );

  // R6: a start is only taken while idle
  assign accept = start_i && !busy_q;

  cs_dly_prescale u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (accept),
    .run_i     (busy_q),
    .pre_len_i (cfg_q.pre_len),
    .tick_o    (tick)
  );

  cs_dly_scaler u_scl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (accept),
    .run_i      (busy_q),
    .adv_i      (tick),
    .scl_last_i (cfg_q.scl_last),
    .wrap_o     (wrap)
  );

  // Next-state logic
  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    cfg_d  = cfg_q;
    if (accept) begin
      busy_d = 1'b1;
      cfg_d  = cfg_live;   // R7: fields captured here only
    end else if (busy_q && wrap) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (accept) cfg_q <= cfg_d;
  end

  assign done_o = done_q;

  // R5: the pulse lasts one cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R5: a pulse only ends a running wait
  a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(busy_q) && !busy_q));
  // R6/R7: captured settings hold while a wait runs
  a_r7_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !wrap) |=> $stable(cfg_q));
  // R6: a start while busy leaves the timer busy
  a_r6_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && !wrap) |=> busy_q);
endmodule

// File: tb/spi_cs_delay_timer_bench.sv
module spi_cs_delay_timer_bench;
  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic       sel_i;
  logic [1:0] lead_pre_i, trail_pre_i;
  logic [3:0] lead_scl_i, trail_scl_i;
  logic       done_o;

  int n_checks;
  int n_fail;
  int cycles;

  spi_cs_delay_timer u_spi_cs_delay_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .sel_i       (sel_i),
    .lead_pre_i  (lead_pre_i),
    .lead_scl_i  (lead_scl_i),
    .trail_pre_i (trail_pre_i),
    .trail_scl_i (trail_scl_i),
    .done_o      (done_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  // Watchdog
  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 195000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles, expected fewer than 195000", cycles);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  function automatic int exp_pre(input logic [1:0] c);
    return 2 * int'(c) + 1;
  endfunction

  function automatic int exp_scl(input logic [3:0] n);
    return 1 << (int'(n) + 1);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // mode 0: plain; 1: extra start mid-wait; 2: fields rewritten mid-wait
  task automatic measure(input logic s, input logic [1:0] lp, input logic [3:0] ls,
                         input logic [1:0] tp, input logic [3:0] ts,
                         input int mode, input string req);
    int lat;
    int exp;
    int extra;
    exp = (s == 1'b1) ? exp_pre(tp) * exp_scl(ts) : exp_pre(lp) * exp_scl(ls);
    @(negedge clk);
    sel_i = s; lead_pre_i = lp; lead_scl_i = ls; trail_pre_i = tp; trail_scl_i = ts;
    start_i = 1'b1;
    @(posedge clk);
    lat = 0;
    @(negedge clk);
    start_i = 1'b0;
    while (1) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (done_o) break;
      start_i = 1'b0;
      if (lat == 1 && mode == 1) begin
        start_i = 1'b1;
        sel_i = ~s; lead_pre_i = ~lp; lead_scl_i = ~ls; trail_pre_i = ~tp; trail_scl_i = ~ts;
      end
      if (lat == 1 && mode == 2) begin
        sel_i = ~s; lead_pre_i = ~lp; lead_scl_i = ~ls; trail_pre_i = ~tp; trail_scl_i = ~ts;
      end
      if (lat > 70000) break;
    end
    start_i = 1'b0;
    check(req, lat, exp);
    @(negedge clk);
    check("R5 pulse width", int'(done_o), 0);
    if (mode == 1) begin
      extra = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (done_o) extra++;
      end
      check("R6 no queued done", extra, 0);
    end
  endtask

  initial begin
    n_checks = 0;
    n_fail = 0;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0;
    start_i = 1'b0; sel_i = 1'b0;
    lead_pre_i = '0; lead_scl_i = '0; trail_pre_i = '0; trail_scl_i = '0;
    repeat (3) @(negedge clk);
    check("R9 reset done low", int'(done_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 idle done low", int'(done_o), 0);

    // R1 every prescaler code, smallest scaler; R4 lead path
    for (int c = 0; c < 4; c++)
      measure(1'b0, 2'(c), 4'd0, 2'd3, 4'd5, 0, "R1 R3 lead prescaler");
    // R4 trail path with different lead fields
    for (int c = 0; c < 4; c++)
      measure(1'b1, 2'd0, 4'd3, 2'(c), 4'd2, 0, "R4 R3 trail prescaler");
    // R2 extremes
    measure(1'b0, 2'd0, 4'd15, 2'd0, 4'd0, 0, "R2 R8 largest scaler");
    measure(1'b1, 2'd1, 4'd0, 2'd3, 4'd12, 0, "R8 largest prescaler long");
    // R6 start while busy, R7 field change while busy
    measure(1'b0, 2'd1, 4'd2, 2'd2, 4'd1, 1, "R6 start ignored");
    measure(1'b1, 2'd2, 4'd0, 2'd1, 4'd3, 2, "R7 fields captured");

    // Random mix
    for (int k = 0; k < 30; k++) begin
      logic       rs;
      logic [1:0] rlp, rtp;
      logic [3:0] rls, rts;
      rs  = 1'($urandom);
      rlp = 2'($urandom); rtp = 2'($urandom);
      rls = 4'($urandom % 8); rts = 4'($urandom % 8);
      measure(rs, rlp, rls, rtp, rts, int'($urandom % 3), "R2 R3 random");
    end

    // R9 reset mid-wait cancels the pending pulse (P=3, S=4: 12 cycles)
    @(negedge clk);
    sel_i = 1'b0; lead_pre_i = 2'd1; lead_scl_i = 4'd1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 done low in reset", int'(done_o), 0);
    rst_n = 1'b1;
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (done_o) seen++;
      end
      check("R9 wait cancelled", seen, 0);
    end
    measure(1'b0, 2'd1, 4'd1, 2'd0, 4'd0, 0, "R9 R3 after reset");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule